// File: doc/BRIEF.md
# Global-History Two-Level Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps one shift register of recent branch outcomes, shared by every branch in the program. It also keeps a table of 2-bit saturating counters. The table is addressed by the low bits of the branch address placed above the current history bits. Different paths leading to the same branch therefore train different counters.

The prediction is combinational and always present. The fetch stage drives the low address bits and reads back the direction and the table index used in the same cycle. It keeps that index with the branch. When the branch resolves, the pipeline returns the kept index and the real outcome. The block then trains exactly that counter and shifts the outcome into the history, so the update is correct even if the history has moved on in between.

Entries carry no tag. Any two branches that form the same index share one counter.

Top module: `ghist_predictor`

## Requirements
- R1: After reset every counter holds 1 (weakly not-taken) and the history register is zero, so every prediction is not-taken and the history field of `pred_idx` is 0.
- R2: `pred_idx` is formed with `pred_pc_lo` in the upper `PC_W` bits and the history in the lower `HIST_W` bits.
- R3: `pred_taken` is 1 exactly when the selected counter is 2 or 3.
- R4: A taken resolve adds one to the counter at `res_idx`, holding at 3.
- R5: A not-taken resolve subtracts one from the counter at `res_idx`, holding at 0.
- R6: A resolve changes only the counter at `res_idx`; a cycle without a resolve changes no counter.
- R7: On a resolve, the history shifts left by one, `res_taken` (1 = taken) enters bit 0, and the oldest bit is lost. Without a resolve the history holds.
- R8: When a predict and a resolve happen in the same cycle, the prediction uses the counter and history values from before that resolve.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| pred_pc_lo | input | PC_W | Low bits of the branch address being predicted |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_idx | output | PC_W+HIST_W | Table index used for this prediction |
| res_valid | input | 1 | A branch resolves this cycle |
| res_idx | input | PC_W+HIST_W | Index captured when the resolving branch was predicted |
| res_taken | input | 1 | Actual outcome, 1 = taken |

## Verification
The bench first sweeps every address under a cleared history, which separates the index layout from the reset value of the counters.

A run of taken resolves on one entry, followed by not-taken ones, walks the counter through both saturation points and across the 1/2 threshold. A crafted outcome sequence then steers the history back onto that entry, so the counter value can be read through a normal prediction.

Predicting and resolving the same entry in one cycle separates pre-update reads from a forwarded value. A long random mix of predicts and resolves, with snapshot indices that no longer match the current history, catches updates that go to the wrong entry or that disturb neighbouring entries.

// File: rtl/bp_pkg.sv
package bp_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_RESET = 2'd1;
  localparam ctr_t CTR_MAX   = 2'd3;
  localparam ctr_t CTR_MIN   = 2'd0;

  // Saturating step of a 2-bit counter toward the observed outcome.
  function automatic ctr_t ctr_next(input ctr_t cur, input logic taken);
    ctr_t res;
    if (taken) res = (cur == CTR_MAX) ? CTR_MAX : ctr_t'(cur + 2'd1);
    else       res = (cur == CTR_MIN) ? CTR_MIN : ctr_t'(cur - 2'd1);
    return res;
  endfunction

  // Direction encoded by a counter: upper half means taken.
  function automatic logic ctr_says_taken(input ctr_t cur);
    return cur >= 2'd2;
  endfunction

endpackage

// File: rtl/bp_history_reg.sv
module bp_history_reg #(
  parameter int HIST_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              shift_in,
  output logic [HIST_W-1:0] hist
);

  logic [HIST_W-1:0] hist_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        hist_q <= '0;
    else if (shift_en) hist_q <= {hist_q[HIST_W-2:0], shift_in};
  end

  assign hist = hist_q;

  // R7
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(hist_q));

  // R7
  hist_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> hist_q[0] == $past(shift_in));

endmodule

// File: rtl/bp_index_form.sv
module bp_index_form #(
  parameter int PC_W   = 4,
  parameter int HIST_W = 6,
  localparam int IDX_W = PC_W + HIST_W
) (
  input  logic [PC_W-1:0]   pc_lo,
  input  logic [HIST_W-1:0] hist,
  output logic [IDX_W-1:0]  idx
);

  assign idx = {pc_lo, hist};

endmodule

// File: rtl/bp_counter_table.sv
module bp_counter_table
  import bp_pkg::*;
#(
  parameter int IDX_W = 10,
  localparam int ENTRIES = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_taken,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);

  ctr_t tbl_q [ENTRIES];

  // Named internal events for the checks below.
  ctr_t rd_ctr;
  ctr_t upd_old;
  ctr_t upd_new;

  assign rd_ctr   = tbl_q[rd_idx];
  assign rd_taken = ctr_says_taken(rd_ctr);
  assign upd_old  = tbl_q[wr_idx];
  assign upd_new  = ctr_next(upd_old, wr_taken);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) tbl_q[i] <= CTR_RESET;
    end else if (wr_en) begin
      tbl_q[wr_idx] <= upd_new;
    end
  end

  // R4
  sat_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_taken && upd_old == 2'd3 |=> tbl_q[$past(wr_idx)] == 2'd3);

  // R4
  step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_taken && upd_old == 2'd1 |=> tbl_q[$past(wr_idx)] == 2'd2);

  // R5
  sat_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_taken && upd_old == 2'd0 |=> tbl_q[$past(wr_idx)] == 2'd0);

  // R6
  no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> tbl_q[$past(rd_idx)] == $past(rd_ctr));

endmodule

// File: rtl/ghist_predictor.sv
module ghist_predictor #(
  parameter int PC_W   = 4,
  parameter int HIST_W = 6,
  localparam int IDX_W = PC_W + HIST_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PC_W-1:0]  pred_pc_lo,
  output logic             pred_taken,
  output logic [IDX_W-1:0] pred_idx,
  input  logic             res_valid,
  input  logic [IDX_W-1:0] res_idx,
  input  logic             res_taken
);

  logic [HIST_W-1:0] hist;

  bp_history_reg #(.HIST_W(HIST_W)) u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (res_valid),
    .shift_in (res_taken),
    .hist     (hist)
  );

  bp_index_form #(.PC_W(PC_W), .HIST_W(HIST_W)) u_idx (
    .pc_lo (pred_pc_lo),
    .hist  (hist),
    .idx   (pred_idx)
  );

  bp_counter_table #(.IDX_W(IDX_W)) u_tbl (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (pred_idx),
    .rd_taken (pred_taken),
    .wr_en    (res_valid),
    .wr_idx   (res_idx),
    .wr_taken (res_taken)
  );

  // R2
  idx_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pred_idx[IDX_W-1:HIST_W] == pred_pc_lo);

endmodule

// File: tb/ghist_predictor_tb.sv
module ghist_predictor_tb_top;

  localparam int CLK_P   = 10;
  localparam int PC_W    = 4;
  localparam int HIST_W  = 6;
  localparam int IDX_W   = PC_W + HIST_W;
  localparam int ENTRIES = 1 << IDX_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [PC_W-1:0]  pred_pc_lo = '0;
  logic             pred_taken;
  logic [IDX_W-1:0] pred_idx;
  logic             res_valid = 1'b0;
  logic [IDX_W-1:0] res_idx = '0;
  logic             res_taken = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Behavioural reference state.
  int mdl_ctr [ENTRIES];
  int mdl_hist;

  always #(CLK_P/2) clk = ~clk;

  ghist_predictor #(.PC_W(PC_W), .HIST_W(HIST_W)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .pred_pc_lo (pred_pc_lo),
    .pred_taken (pred_taken),
    .pred_idx   (pred_idx),
    .res_valid  (res_valid),
    .res_idx    (res_idx),
    .res_taken  (res_taken)
  );

  task automatic check(input bit ok, input string tag, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // One cycle: drive at the falling edge, compare outputs against the
  // model's pre-edge state, then advance the model as the edge will.
  task automatic step(input int pc, input bit rv, input int ri, input bit rt,
                      input string tag);
    int eidx;
    int c;
    @(negedge clk);
    pred_pc_lo = PC_W'(pc);
    res_valid  = rv;
    res_idx    = IDX_W'(ri);
    res_taken  = rt;
    #1;
    eidx = (pc << HIST_W) | mdl_hist;
    check(int'(pred_idx) / (1 << HIST_W) == pc, "R2", int'(pred_idx) / (1 << HIST_W), pc);
    check(int'(pred_idx) % (1 << HIST_W) == mdl_hist, "R7", int'(pred_idx) % (1 << HIST_W), mdl_hist);
    check(pred_taken == (mdl_ctr[eidx] > 1), tag, int'(pred_taken), int'(mdl_ctr[eidx] > 1));
    if (rv) begin
      c = mdl_ctr[ri];
      if (rt) c = (c == 3) ? 3 : c + 1;
      else    c = (c == 0) ? 0 : c - 1;
      mdl_ctr[ri] = c;
      mdl_hist = ((mdl_hist << 1) | int'(rt)) % (1 << HIST_W);
    end
  endtask

  initial begin
    int a;
    int b;
    for (int i = 0; i < ENTRIES; i++) mdl_ctr[i] = 1;
    mdl_hist = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: every address predicts not-taken, history field clear
    for (int p = 0; p < (1 << PC_W); p++) step(p, 0, 0, 0, "R1");

    // R4: train one entry up past saturation
    a = (3 << HIST_W);
    for (int k = 0; k < 5; k++) step(3, 1, a, 1, "R4");
    // steer history back to zero with not-taken resolves elsewhere
    b = (5 << HIST_W) | 6'h2A;
    for (int k = 0; k < 6; k++) step(5, 1, b, 0, "R5");
    step(3, 0, 0, 0, "R3");
    // R8: predict and resolve the same entry in one cycle
    step(3, 1, a, 0, "R8");
    step(3, 1, a, 0, "R8");
    // R3: now at 1, below the threshold
    step(3, 0, 0, 0, "R3");

    // R5: drive the other entry further down, then read it back
    for (int k = 0; k < 3; k++) step(0, 1, b, 0, "R5");
    step(1, 1, 7, 1, "R7");
    step(1, 1, 7, 0, "R7");
    step(1, 1, 7, 1, "R7");
    step(1, 1, 7, 0, "R7");
    step(1, 1, 7, 1, "R7");
    step(1, 1, 7, 0, "R7");
    step(5, 0, 0, 0, "R5");
    step(5, 1, b, 1, "R5");
    step(9, 0, 0, 0, "R7");

    // R6: sweep all addresses under the current history
    for (int p = 0; p < (1 << PC_W); p++) step(p, 0, 0, 0, "R6");

    // R6: long random mix with stale snapshot indices
    for (int k = 0; k < 4000; k++) begin
      step(int'($urandom_range((1 << PC_W) - 1)), bit'($urandom_range(1)),
           int'($urandom_range(ENTRIES - 1)), bit'($urandom_range(1)), "R6");
    end

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule